// File: doc/BRIEF.md
# Supply On/Off Sequencer with Fault Latch

This block decides whether the main outputs of a switching power supply may run. It takes an active-low remote on/off request from the host, together with per-rail over-voltage, under-voltage and over-current flags from external comparators. It drives one output, `rails_off`, which is high whenever the main outputs must be held down.

The request is synchronised and then filtered on both edges. After a filtered release of the request, the outputs are kept running for a short additional hold. After a filtered turn-on, the under-voltage and over-current checks are masked for a settling window. Any fault that persists past a short qualification time is latched. The latch forces `rails_off` high until the request makes a filtered low-to-high transition or the block is reset.

All timing is counted in ticks of one shared prescaler. For observation, the block emits a one-cycle pulse when the latch sets, and it keeps a bitmask of the fault kinds that have been latched.

Top module: `onoff_fault_ctl`

## Requirements
- R1: While `rst_n` is low and after it rises, `rails_off` is 1, `fault_kind` is 0 and `fault_pulse` is 0.
- R2: A change of `req_n` takes effect only after the synchronised value has differed from the accepted value for DEB_TICKS consecutive ticks. A shorter excursion is ignored, on either edge. When the accepted request is low and no fault is latched, `rails_off` goes to 0.
- R3: After the accepted request goes high, `rails_off` stays 0 for an additional OFF_HOLD_TICKS ticks before it goes to 1.
- R4: For BLANK_TICKS ticks after the accepted request goes low, under-voltage and over-current flags are ignored. Over-voltage flags are never masked.
- R5: A fault flag (the OR of one kind across all rails) counts only when it stays asserted for more than QUAL_TICKS ticks. A shorter pulse leaves `rails_off`, `fault_kind` and `fault_pulse` untouched.
- R6: A qualified fault latches, and while latched it holds `rails_off` at 1. `fault_pulse` is high for exactly one cycle when the latch sets. In `fault_kind`, bit 0 marks over-voltage, bit 1 under-voltage and bit 2 over-current; the bits accumulate while the latch is set.
- R7: The latch and `fault_kind` clear only on an accepted low-to-high transition of the request, or on reset. A request that stays low does not clear them.
- R8: An over-voltage fault qualified while the request is high is still latched. At the next turn-on, `rails_off` stays 1.
- R9: While the outputs are off, under-voltage and over-current flags are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_n | input | 1 | Asynchronous remote request, low means run |
| ov_flag | input | RAILS | Over-voltage comparator outputs, one per rail |
| uv_flag | input | RAILS | Under-voltage comparator outputs, one per rail |
| oc_flag | input | RAILS | Over-current comparator outputs, one per rail |
| rails_off | output | 1 | High holds the main outputs off |
| fault_pulse | output | 1 | One-cycle pulse when the fault latch sets |
| fault_kind | output | 3 | Latched fault kinds: bit 0 OV, bit 1 UV, bit 2 OC |

## Verification
The prescaler phase is free-running, so a filtered request change lands between two sync cycles plus DEB_TICKS-1 ticks and two sync cycles plus DEB_TICKS ticks after the input moves, with one more cycle for the output register. For each result the bench therefore samples once before the earliest possible cycle, where the old value must still hold, and once after the latest, where the new value must be present. The off-hold, blanking and qualification windows are checked the same way, each bound widened by one tick. `fault_pulse` is counted on every falling clock edge, so a missing pulse or an extra one shows up as a wrong count after each scenario.

// File: rtl/onoff_fault_ctl.sv
module onoff_fault_ctl #(
  parameter int RAILS          = 3,
  parameter int PRESCALE       = 4,
  parameter int DEB_TICKS      = 8,
  parameter int OFF_HOLD_TICKS = 3,
  parameter int BLANK_TICKS    = 10,
  parameter int QUAL_TICKS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_n,
  input  logic [RAILS-1:0] ov_flag,
  input  logic [RAILS-1:0] uv_flag,
  input  logic [RAILS-1:0] oc_flag,
  output logic             rails_off,
  output logic             fault_pulse,
  output logic [2:0]       fault_kind
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int HW = $clog2(OFF_HOLD_TICKS + 1);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int QW = $clog2(QUAL_TICKS + 1);

  logic [PW-1:0] pre_cnt;
  logic          tick;
  logic [1:0]    sync;
  logic          req_ok, req_ok_d;
  logic [DW-1:0] deb_cnt;
  logic          run_q;
  logic [HW-1:0] hold_cnt;
  logic [BW-1:0] blank_cnt;
  logic          acc_rise, acc_fall, uvoc_en;
  logic [2:0]    live, qual;
  logic          latched;

  assign tick     = (pre_cnt == PW'(PRESCALE - 1));
  assign acc_rise = req_ok & ~req_ok_d;
  assign acc_fall = ~req_ok & req_ok_d;
  assign uvoc_en  = run_q & (blank_cnt == '0);
  assign live     = {(|oc_flag) & uvoc_en, (|uv_flag) & uvoc_en, |ov_flag};
  assign rails_off = ~run_q | latched;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], req_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_ok   <= 1'b1;
      req_ok_d <= 1'b1;
      deb_cnt  <= '0;
    end else begin
      req_ok_d <= req_ok;
      if (sync[1] == req_ok) deb_cnt <= '0;
      else if (tick) begin
        if (deb_cnt == DW'(DEB_TICKS - 1)) begin
          req_ok  <= sync[1];
          deb_cnt <= '0;
        end else deb_cnt <= deb_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (!req_ok) begin
      run_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (run_q && tick) begin
      if (hold_cnt == HW'(OFF_HOLD_TICKS - 1)) begin
        run_q    <= 1'b0;
        hold_cnt <= '0;
      end else hold_cnt <= hold_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        blank_cnt <= '0;
    else if (acc_fall)                 blank_cnt <= BW'(BLANK_TICKS);
    else if (tick && blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;

  for (genvar k = 0; k < 3; k++) begin : g_qual
    logic [QW-1:0] q_cnt;
    assign qual[k] = live[k] & tick & (q_cnt == QW'(QUAL_TICKS));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                      q_cnt <= '0;
      else if (!live[k])                               q_cnt <= '0;
      else if (tick && q_cnt != QW'(QUAL_TICKS))       q_cnt <= q_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latched     <= 1'b0;
      fault_kind  <= '0;
      fault_pulse <= 1'b0;
    end else begin
      fault_pulse <= (|qual) & ~latched;
      if (acc_rise) begin
        latched    <= |qual;
        fault_kind <= qual;
      end else begin
        latched    <= latched | (|qual);
        fault_kind <= fault_kind | qual;
      end
    end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse); // R6
  AST_PULSE_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> fault_kind != 3'b000); // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !acc_rise |=> latched); // R7
  AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(req_ok)); // R2
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ok) && run_q |=> run_q); // R3
  AST_BLANK_UVOC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fall |=> !qual[1] && !qual[2]); // R4
endmodule

// File: tb/test_onoff_fault_ctl.sv
`timescale 1ns/1ps
module test_onoff_fault_ctl;
  localparam int RAILS = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic [RAILS-1:0] ov = '0, uv = '0, oc = '0;
  logic rails_off, fault_pulse;
  logic [2:0] fault_kind;
  int checks = 0, errors = 0, pulses = 0, base = 0;

  always #2.5 clk = ~clk;

  onoff_fault_ctl i_onoff_fault_ctl (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .ov_flag(ov), .uv_flag(uv), .oc_flag(oc),
    .rails_off(rails_off), .fault_pulse(fault_pulse), .fault_kind(fault_kind)
  );

  always @(negedge clk) if (rst_n && fault_pulse) pulses++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    wait_n(3);
    check("R1 rails_off in reset", rails_off, 1);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 rails_off after reset", rails_off, 1);
    check("R1 fault_kind after reset", fault_kind, 0);
    check("R1 fault_pulse count", pulses, 0);
  endtask

  task automatic t_glitch;
    req_n = 1'b0; wait_n(10);
    req_n = 1'b1; wait_n(80);
    check("R2 short low excursion ignored", rails_off, 1);
  endtask

  task automatic t_turn_on;
    req_n = 1'b0; wait_n(24);
    check("R2 on not before debounce", rails_off, 1);
    wait_n(24);
    check("R2 on after debounce", rails_off, 0);
    req_n = 1'b1; wait_n(8);
    req_n = 1'b0; wait_n(80);
    check("R2 short high excursion ignored", rails_off, 0);
  endtask

  task automatic t_turn_off;
    req_n = 1'b1; wait_n(38);
    check("R3 outputs held during off hold", rails_off, 0);
    wait_n(32);
    check("R3 outputs off after hold", rails_off, 1);
  endtask

  task automatic t_blank_and_clear;
    base = pulses;
    uv[0] = 1'b1;
    req_n = 1'b0; wait_n(60);
    check("R4 UV masked in blank window", rails_off, 0);
    wait_n(70);
    check("R4 UV counted after blank window", rails_off, 1);
    check("R6 kind is UV", fault_kind, 2);
    check("R6 one pulse for UV", pulses - base, 1);
    uv[0] = 1'b0; wait_n(50);
    check("R7 latch held while request low", rails_off, 1);
    req_n = 1'b1; wait_n(80);
    check("R7 kind cleared on release", fault_kind, 0);
    req_n = 1'b0; wait_n(60);
    check("R7 latch cleared, outputs run", rails_off, 0);
    wait_n(100);
  endtask

  task automatic t_qualify;
    base = pulses;
    ov[1] = 1'b1; wait_n(5);
    ov[1] = 1'b0; wait_n(20);
    check("R5 short OV pulse ignored", rails_off, 0);
    check("R5 no kind for short OV", fault_kind, 0);
    check("R5 no pulse for short OV", pulses - base, 0);
    ov[1] = 1'b1; wait_n(20);
    ov[1] = 1'b0; wait_n(2);
    check("R6 OV latched", rails_off, 1);
    check("R6 kind is OV", fault_kind, 1);
    check("R6 one pulse for OV", pulses - base, 1);
    wait_n(100);
    check("R6 latch persists after flag", rails_off, 1);
  endtask

  task automatic t_while_off;
    req_n = 1'b1; wait_n(80);
    check("R7 kind cleared by release", fault_kind, 0);
    base = pulses;
    uv[2] = 1'b1; oc[0] = 1'b1; wait_n(60);
    uv[2] = 1'b0; oc[0] = 1'b0; wait_n(4);
    check("R9 UV/OC ignored while off", fault_kind, 0);
    check("R9 no pulse while off", pulses - base, 0);
    ov[0] = 1'b1; wait_n(20);
    ov[0] = 1'b0; wait_n(4);
    check("R8 OV latched while off", fault_kind, 1);
    check("R8 pulse while off", pulses - base, 1);
    req_n = 1'b0; wait_n(80);
    check("R8 latch blocks next turn-on", rails_off, 1);
    req_n = 1'b1; wait_n(80);
    req_n = 1'b0; wait_n(130);
    check("R7 toggle clears latch", rails_off, 0);
  endtask

  task automatic t_overcurrent;
    base = pulses;
    oc[2] = 1'b1; wait_n(20);
    oc[2] = 1'b0; wait_n(2);
    check("R6 OC latched", rails_off, 1);
    check("R6 kind is OC", fault_kind, 4);
    check("R6 one pulse for OC", pulses - base, 1);
  endtask

  task automatic t_por;
    rst_n = 1'b0; wait_n(3);
    rst_n = 1'b1; wait_n(2);
    check("R7 reset clears kind", fault_kind, 0);
    check("R1 rails_off after second reset", rails_off, 1);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_turn_on();
    t_turn_off();
    t_blank_and_clear();
    t_qualify();
    t_while_off();
    t_overcurrent();
    t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule